// File: doc/BRIEF.md
# Two-Plane Cache Program Status Tracker

This block models the device-side status byte and the ready/busy line of a flash device while it runs a pipelined two-plane cache program. It receives already-decoded command strobes: the first-plane load confirm, the cache program confirm, the final program confirm and the status read. It also receives one program-error flag per plane. Two internal counters time the busy periods, with lengths taken from input ports: a short busy after the first-plane confirm, a cache-to-data-register transfer, and an array program.

The tracker keeps two readiness flags. One shows whether the cache registers can take new data. The other shows whether the array program of the data registers has finished. It also keeps two pass/fail generations: one for the page pair now being programmed and one for the pair programmed before it. The error flags of both planes are merged into a single fail bit.

A host issues the status read strobe and reads the captured byte on the next cycle. The host uses the ready/busy output to pace its command stream.

Top module: `plane_cache_status`

## Requirements
- R1: After synchronous reset `readyBusy` is 1 and `statusByte` is 8'h60. Status bit 6 is cache ready, bit 5 is array idle, bit 1 is previous-pair fail and bit 0 is current-pair fail. Bits 7, 4, 3 and 2 are always 0.
- R2: An accepted first-plane confirm drives `readyBusy` low for exactly `dummyLen` cycles, starting the cycle after the strobe. A length of 0 counts as 1. The array state is not changed.
- R3: An accepted cache confirm with the array idle keeps bit 6 and `readyBusy` low for `xferLen` cycles. When they return high, bit 5 drops and stays low for exactly `progLen` cycles.
- R4: A cache confirm accepted while the array is busy holds the transfer until the cycle after the array finishes. `readyBusy` stays low for that whole time.
- R5: When an array program starts, the current-pair fail bit moves into the previous-pair bit and the current-pair bit is cleared.
- R6: When an array program completes, the current-pair fail bit is set if any plane's `planeFail` flag is high in the last program cycle (logical OR).
- R7: After an accepted final confirm, `readyBusy` stays low until both the transfer and the array program it starts have completed. Bit 6 may return to 1 before that.
- R8: Load and confirm strobes that arrive while `readyBusy` is low are ignored.
- R9: If several confirm strobes arrive in one cycle, the final confirm wins over the cache confirm, which wins over the first-plane confirm.
- R10: A status read strobe captures the live status byte at that clock edge. The captured byte appears on `statusByte` the next cycle and is held until the next read.
- R11: Asserting `rst` during any busy period returns the block to the R1 state at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdPlaneDone | input | 1 | First-plane load confirm strobe |
| cmdCacheGo | input | 1 | Cache program confirm strobe |
| cmdFinalGo | input | 1 | Final program confirm strobe |
| cmdReadStatus | input | 1 | Status read strobe |
| dummyLen | input | TW | Busy length after first-plane confirm, in cycles |
| xferLen | input | TW | Cache transfer length, in cycles |
| progLen | input | TW | Array program length, in cycles |
| planeFail | input | NP | Per-plane program error flags |
| statusByte | output | 8 | Status byte captured by the last read |
| readyBusy | output | 1 | 1 = ready, 0 = busy |

## Verification
A strobe sampled at edge E0 makes `readyBusy` fall right after E0. The line rises again after edge E(dummyLen), E(xferLen), or E(xferLen+progLen) after a final confirm. A captured status byte is due one cycle after its read strobe. The bench drives at the falling edge and samples `readyBusy` half a cycle after each counted edge. Its driver queues the expected byte for every read, and a monitor pops it on the falling edge after the read edge. Reads are placed exactly on the last busy cycle and on the first free cycle, so an off-by-one in any counter changes a compared byte.

// File: rtl/cpst_pkg.sv
package cpst_pkg;

  localparam int STATUS_W      = 8;
  localparam int BIT_CACHE_RDY = 6;
  localparam int BIT_ARRAY_RDY = 5;
  localparam int BIT_PREV_FAIL = 1;
  localparam int BIT_CURR_FAIL = 0;
  localparam logic [STATUS_W-1:0] STATUS_RESET =
    (STATUS_W'(1) << BIT_CACHE_RDY) | (STATUS_W'(1) << BIT_ARRAY_RDY);

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_DUMMY = 2'd1,
    CS_WAIT  = 2'd2,
    CS_XFER  = 2'd3
  } cacheState_t;

  typedef struct packed {
    logic startProg;
    logic progDone;
    logic snapStatus;
  } dpStrobe_t;

endpackage

// File: rtl/cpst_busy_timer.sv
module cpst_busy_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] len,
  output logic          busy,
  output logic          done
);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= (len == '0) ? '0 : len - 1'b1;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assign done = busy && (remain == '0);

endmodule

// File: rtl/cpst_ctrl.sv
module cpst_ctrl import cpst_pkg::*; #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdPlaneDone,
  input  logic          cmdCacheGo,
  input  logic          cmdFinalGo,
  input  logic          cmdReadStatus,
  input  logic [TW-1:0] dummyLen,
  input  logic [TW-1:0] xferLen,
  input  logic [TW-1:0] progLen,
  output dpStrobe_t     strobe,
  output logic          cacheReady,
  output logic          arrayIdle,
  output logic          readyBusy
);

  cacheState_t state, stateNext;
  logic          cacheStart, cacheBusy, cacheDone;
  logic [TW-1:0] cacheLen;
  logic          arrStart, arrBusy, arrDone;
  logic          finalPending, finalArmed;
  logic          goFinal, goCache, goDummy, goXfer;

  // Priority among confirms: final, then cache, then first-plane.
  always_comb begin
    goFinal = readyBusy && cmdFinalGo;
    goCache = readyBusy && cmdCacheGo && !cmdFinalGo;
    goDummy = readyBusy && cmdPlaneDone && !cmdCacheGo && !cmdFinalGo;
    goXfer  = goFinal || goCache;
  end

  always_comb begin
    stateNext  = state;
    cacheStart = 1'b0;
    cacheLen   = xferLen;
    arrStart   = 1'b0;
    case (state)
      CS_IDLE: begin
        if (goDummy) begin
          stateNext  = CS_DUMMY;
          cacheStart = 1'b1;
          cacheLen   = dummyLen;
        end else if (goXfer) begin
          if (arrBusy) begin
            stateNext = CS_WAIT;
          end else begin
            stateNext  = CS_XFER;
            cacheStart = 1'b1;
          end
        end
      end
      CS_DUMMY: if (cacheDone) stateNext = CS_IDLE;
      CS_WAIT: begin
        if (!arrBusy) begin
          stateNext  = CS_XFER;
          cacheStart = 1'b1;
        end
      end
      CS_XFER: begin
        if (cacheDone) begin
          stateNext = CS_IDLE;
          arrStart  = 1'b1;
        end
      end
      default: stateNext = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= CS_IDLE;
    else     state <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      finalPending <= 1'b0;
      finalArmed   <= 1'b0;
    end else begin
      if (goFinal) finalPending <= 1'b1;
      if (arrStart && finalPending) finalArmed <= 1'b1;
      if (arrDone && finalArmed) begin
        finalPending <= 1'b0;
        finalArmed   <= 1'b0;
      end
    end
  end

  cpst_busy_timer #(.TW(TW)) u_cacheTimer (
    .clk(clk), .rst(rst), .start(cacheStart), .len(cacheLen),
    .busy(cacheBusy), .done(cacheDone)
  );

  cpst_busy_timer #(.TW(TW)) u_arrayTimer (
    .clk(clk), .rst(rst), .start(arrStart), .len(progLen),
    .busy(arrBusy), .done(arrDone)
  );

  assign cacheReady        = (state == CS_IDLE) && !cacheBusy;
  assign arrayIdle         = !arrBusy;
  assign readyBusy         = cacheReady && !finalPending;
  assign strobe.startProg  = arrStart;
  assign strobe.progDone   = arrDone;
  assign strobe.snapStatus = cmdReadStatus;

endmodule

// File: rtl/cpst_dp.sv
module cpst_dp import cpst_pkg::*; #(
  parameter int NP = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  dpStrobe_t           strobe,
  input  logic                cacheReady,
  input  logic                arrayIdle,
  input  logic [NP-1:0]       planeFail,
  output logic [STATUS_W-1:0] liveStatus,
  output logic [STATUS_W-1:0] statusByte
);

  logic prevFail, currFail;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevFail <= 1'b0;
      currFail <= 1'b0;
    end else if (strobe.startProg) begin
      prevFail <= currFail;
      currFail <= 1'b0;
    end else if (strobe.progDone) begin
      currFail <= currFail | (|planeFail);
    end
  end

  always_comb begin
    liveStatus                = '0;
    liveStatus[BIT_CACHE_RDY] = cacheReady;
    liveStatus[BIT_ARRAY_RDY] = arrayIdle;
    liveStatus[BIT_PREV_FAIL] = prevFail;
    liveStatus[BIT_CURR_FAIL] = currFail;
  end

  always_ff @(posedge clk) begin
    if (rst)                   statusByte <= STATUS_RESET;
    else if (strobe.snapStatus) statusByte <= liveStatus;
  end

endmodule

// File: rtl/plane_cache_status.sv
module plane_cache_status import cpst_pkg::*; #(
  parameter int TW = 8,
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdPlaneDone,
  input  logic          cmdCacheGo,
  input  logic          cmdFinalGo,
  input  logic          cmdReadStatus,
  input  logic [TW-1:0] dummyLen,
  input  logic [TW-1:0] xferLen,
  input  logic [TW-1:0] progLen,
  input  logic [NP-1:0] planeFail,
  output logic [7:0]    statusByte,
  output logic          readyBusy
);

  dpStrobe_t           strobe;
  logic                cacheReady, arrayIdle;
  logic [STATUS_W-1:0] liveStatus;

  cpst_ctrl #(.TW(TW)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmdPlaneDone(cmdPlaneDone), .cmdCacheGo(cmdCacheGo),
    .cmdFinalGo(cmdFinalGo), .cmdReadStatus(cmdReadStatus),
    .dummyLen(dummyLen), .xferLen(xferLen), .progLen(progLen),
    .strobe(strobe), .cacheReady(cacheReady), .arrayIdle(arrayIdle),
    .readyBusy(readyBusy)
  );

  cpst_dp #(.NP(NP)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .cacheReady(cacheReady), .arrayIdle(arrayIdle),
    .planeFail(planeFail), .liveStatus(liveStatus),
    .statusByte(statusByte)
  );

endmodule

// File: rtl/cpst_checker.sv
module cpst_checker #(
  parameter int NP = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cmdPlaneDone,
  input logic          cmdCacheGo,
  input logic          cmdFinalGo,
  input logic          cmdReadStatus,
  input logic [NP-1:0] planeFail,
  input logic [7:0]    liveStatus,
  input logic [7:0]    statusByte,
  input logic          readyBusy
);

  logic rstPrev = 1'b0;
  always_ff @(posedge clk) rstPrev <= rst;

  // R1: reset state and always-zero bits
  always @(posedge clk) begin
    if (rstPrev && !rst)
      assert_reset_idle_R1: assert (statusByte == 8'h60 && readyBusy && liveStatus == 8'h60);
    if (!rst && !rstPrev)
      assert_unused_bits_R1: assert ((liveStatus & 8'h9C) == 8'h00);
  end

  assert_accept_goes_busy_R2: assert property (@(posedge clk) disable iff (rst || rstPrev)
    (readyBusy && (cmdPlaneDone || cmdCacheGo || cmdFinalGo)) |=> !readyBusy);

  assert_ready_implies_cache_R3: assert property (@(posedge clk) disable iff (rst || rstPrev)
    readyBusy |-> liveStatus[6]);

  assert_start_shifts_R5: assert property (@(posedge clk) disable iff (rst || rstPrev)
    $fell(liveStatus[5]) |-> (!liveStatus[0] && liveStatus[1] == $past(liveStatus[0])));

  assert_done_merges_R6: assert property (@(posedge clk) disable iff (rst || rstPrev)
    $rose(liveStatus[5]) |-> (liveStatus[0] == ($past(liveStatus[0]) | (|$past(planeFail)))));

  assert_ignored_cmd_R8: assert property (@(posedge clk) disable iff (rst || rstPrev)
    (!readyBusy && liveStatus[6]) |=> liveStatus[6]);

  assert_snapshot_R10: assert property (@(posedge clk) disable iff (rst || rstPrev)
    cmdReadStatus |=> statusByte == $past(liveStatus));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst || rstPrev)
    !cmdReadStatus |=> $stable(statusByte));

endmodule

bind plane_cache_status cpst_checker #(.NP(NP)) u_chk (
  .clk(clk), .rst(rst), .cmdPlaneDone(cmdPlaneDone), .cmdCacheGo(cmdCacheGo),
  .cmdFinalGo(cmdFinalGo), .cmdReadStatus(cmdReadStatus), .planeFail(planeFail),
  .liveStatus(liveStatus), .statusByte(statusByte), .readyBusy(readyBusy)
);

// File: tb/plane_cache_status_tb.sv
`timescale 1ns/1ps
module plane_cache_status_tb;

  localparam int TW = 8;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmdPlaneDone = 1'b0, cmdCacheGo = 1'b0, cmdFinalGo = 1'b0, cmdReadStatus = 1'b0;
  logic [TW-1:0] dummyLen = 8'd2, xferLen = 8'd3, progLen = 8'd6;
  logic [NP-1:0] planeFail = '0;
  logic [7:0]    statusByte;
  logic          readyBusy;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic rdFlag = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  plane_cache_status #(.TW(TW), .NP(NP)) u_dut (
    .clk(clk), .rst(rst), .cmdPlaneDone(cmdPlaneDone), .cmdCacheGo(cmdCacheGo),
    .cmdFinalGo(cmdFinalGo), .cmdReadStatus(cmdReadStatus), .dummyLen(dummyLen),
    .xferLen(xferLen), .progLen(progLen), .planeFail(planeFail),
    .statusByte(statusByte), .readyBusy(readyBusy)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: queues the expected byte, issues a read strobe for one edge
  task automatic readStatus(input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    cmdReadStatus = 1'b1;
    @(negedge clk);
    cmdReadStatus = 1'b0;
  endtask

  // monitor: compares the captured byte one cycle after each read edge
  always @(posedge clk) rdFlag <= cmdReadStatus;
  always @(negedge clk) begin
    if (rdFlag) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: unexpected capture %h expected none", statusByte);
      end else begin
        chk(statusByte, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    chk({7'd0, readyBusy}, 8'd1, "R1 ready after reset");
    chk(statusByte, 8'h60, "R1 reset byte");
    readStatus(8'h60, "R1 live reset status");

    // R2 first-plane confirm, with a cache confirm during busy (R8)
    cmdPlaneDone = 1'b1; tick(1); cmdPlaneDone = 1'b0;
    chk({7'd0, readyBusy}, 8'd0, "R2 busy after E0");
    cmdCacheGo = 1'b1; tick(1); cmdCacheGo = 1'b0;
    chk({7'd0, readyBusy}, 8'd0, "R2 busy after E1");
    tick(1);
    chk({7'd0, readyBusy}, 8'd1, "R2 ready after dummyLen");
    readStatus(8'h60, "R8 cache confirm during busy ignored");
    chk({7'd0, readyBusy}, 8'd1, "R8 still ready");

    // R2 zero length counts as one
    dummyLen = 8'd0;
    cmdPlaneDone = 1'b1; tick(1); cmdPlaneDone = 1'b0;
    chk({7'd0, readyBusy}, 8'd0, "R2 zero-length busy");
    tick(1);
    chk({7'd0, readyBusy}, 8'd1, "R2 zero-length ready");
    dummyLen = 8'd2;

    // pair A: plane 0 fails
    planeFail = 2'b01;
    cmdCacheGo = 1'b1; tick(1); cmdCacheGo = 1'b0;
    chk({7'd0, readyBusy}, 8'd0, "R3 transfer busy");
    tick(2);
    chk({7'd0, readyBusy}, 8'd0, "R3 last transfer cycle");
    tick(1);
    chk({7'd0, readyBusy}, 8'd1, "R3 ready after xferLen");
    readStatus(8'h40, "R3 array busy");
    tick(4);
    readStatus(8'h40, "R3 last program cycle");
    readStatus(8'h61, "R6 plane0 fail merged");

    // pair B: no fail; previous-pair bit takes A's fail
    planeFail = 2'b00;
    cmdCacheGo = 1'b1; tick(1); cmdCacheGo = 1'b0;
    tick(2);
    chk(statusByte, 8'h61, "R10 capture held");
    tick(1);
    readStatus(8'h42, "R5 shift at program start");

    // pair C while B programs
    cmdCacheGo = 1'b1; tick(1); cmdCacheGo = 1'b0;
    chk({7'd0, readyBusy}, 8'd0, "R4 busy while waiting");
    tick(7);
    chk({7'd0, readyBusy}, 8'd0, "R4 last transfer cycle after wait");
    tick(1);
    chk({7'd0, readyBusy}, 8'd1, "R4 ready after waited transfer");
    planeFail = 2'b10;
    readStatus(8'h40, "R5 previous bit cleared from pair B");
    tick(5);
    readStatus(8'h61, "R6 plane1 fail merged");

    // pair D: final and first-plane confirm together
    planeFail = 2'b00;
    cmdFinalGo = 1'b1; cmdPlaneDone = 1'b1; tick(1);
    cmdFinalGo = 1'b0; cmdPlaneDone = 1'b0;
    chk({7'd0, readyBusy}, 8'd0, "R7 busy after final confirm");
    tick(2);
    chk({7'd0, readyBusy}, 8'd0, "R9 final wins over first-plane confirm");
    tick(1);
    chk({7'd0, readyBusy}, 8'd0, "R7 held through program");
    cmdCacheGo = 1'b1;
    readStatus(8'h42, "R7 cache ready while line busy");
    cmdCacheGo = 1'b0;
    tick(4);
    chk({7'd0, readyBusy}, 8'd0, "R7 last program cycle");
    tick(1);
    chk({7'd0, readyBusy}, 8'd1, "R7 ready after program");
    readStatus(8'h62, "R8 confirm during final hold ignored");
    chk({7'd0, readyBusy}, 8'd1, "R8 no transfer started");

    // R11 reset during transfer
    planeFail = 2'b11;
    cmdCacheGo = 1'b1; tick(1); cmdCacheGo = 1'b0;
    rst = 1'b1; tick(1); rst = 1'b0;
    chk({7'd0, readyBusy}, 8'd1, "R11 ready after mid reset");
    chk(statusByte, 8'h60, "R11 capture reset");
    readStatus(8'h60, "R11 live status reset");
    tick(8);
    chk({7'd0, readyBusy}, 8'd1, "R11 no leftover activity");
    readStatus(8'h60, "R11 no program after reset");
    tick(2);
    finish_run();
  end

endmodule